// File: doc/BRIEF.md
# Dual-Channel Sample Demultiplexing Output Pipeline

This block sits behind a two-channel (I and Q) converter core and turns a stream of one code per channel per sample clock into output buses. Each channel has a primary bus and a delayed bus. In full-rate mode only the primary buses move, carrying every sample. In split mode the block deals the samples of each channel out in turn: the first sample of a pair goes to the primary bus and the second to the delayed bus. Both buses then change together on every second clock, so each bus runs at half the sample rate.

Before a sample enters the pipeline, its code is forced to all ones when the channel reports over-range and to all zeros when it reports under-range. Otherwise the offset-binary code passes through unchanged. A single out-of-range flag travels with each sample and reaches the output together with the data it describes. A valid strobe marks each clock on which the primary buses take new data. A change of the mode input flushes everything still in flight, so the output never mixes data from two modes.

Top module: `dmx_out_pipe`

## Requirements
- R1: While reset is high at a clock edge, that edge sets every output bus, valid and the out-of-range flag to zero. The mode in force after reset is the level of the mode input during reset, with no flush.
- R2: A code entering the pipeline is replaced by all ones when its over-range input is 1 (over-range wins when both are 1), by all zeros when only under-range is 1, and is otherwise passed unchanged.
- R3: In full-rate mode (mode input 0), a sample captured at clock edge k appears on the primary I and Q buses at edge k+13, and valid is 1 after that edge.
- R4: In split mode (mode input 1), the samples are counted from the first capture after reset or after a flush, starting at 0. The even-numbered samples appear on the primary buses 13 edges after capture.
- R5: In split mode the odd-numbered samples appear on the delayed buses 14 edges after capture, on the same edge on which the primary buses take the following even sample.
- R6: In full-rate mode the out-of-range flag after edge k+13 is 1 exactly when any of the four range inputs was 1 at capture edge k.
- R7: In split mode the out-of-range flag after a loading edge is 1 when either of the two samples loaded at that edge was out of range. Only the primary sample counts when the delayed bus is not loaded at that edge.
- R8: In full-rate mode the delayed buses keep their last value.
- R9: In split mode valid is 1 only on edges that load the primary buses, so it is never 1 on two edges in a row. The primary buses change on no other edge in either mode.
- R10: An edge at which the mode input differs from the mode in force is a flush edge. The sample present at that edge is dropped, valid is 0 after the flush edge, the output buses hold, and the next captured sample is sample 0 in the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| demux_en | input | 1 | Mode select: 0 full-rate, 1 split |
| i_code | input | CODE_W | I channel sample code, offset binary |
| q_code | input | CODE_W | Q channel sample code, offset binary |
| i_ovr | input | 1 | I sample above positive full scale |
| i_und | input | 1 | I sample below negative full scale |
| q_ovr | input | 1 | Q sample above positive full scale |
| q_und | input | 1 | Q sample below negative full scale |
| pri_i | output | CODE_W | Primary I bus |
| pri_q | output | CODE_W | Primary Q bus |
| dly_i | output | CODE_W | Delayed I bus |
| dly_q | output | CODE_W | Delayed Q bus |
| valid | output | 1 | Primary buses took new data at the last edge |
| oor | output | 1 | Shared out-of-range flag for the loaded data |

## Verification
The bench uses the default parameters: 8-bit codes and a primary latency of 13, so the delayed latency is 14. These are the exact latencies the requirements fix, which lets every output be compared edge by edge against a model of captured samples. The runs are short enough to cross two resets and several mode flushes, including the first split pair after a flush, where the delayed bus still holds old data.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_SPLIT = 1'b1
  } mode_e;

  localparam int unsigned DEF_CODE_W  = 8;
  localparam int unsigned DEF_LAT_PRI = 13;

endpackage

// File: rtl/dmx_front.sv
// Input stage: clamps codes, tracks mode and pair phase, detects flushes.
// Record layout: {vld, phase, oor, i_code, q_code}.
module dmx_front
  import dmx_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  localparam int unsigned REC_W = 2 * CODE_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              demux_en,
  input  logic [CODE_W-1:0] i_code,
  input  logic [CODE_W-1:0] q_code,
  input  logic              i_ovr,
  input  logic              i_und,
  input  logic              q_ovr,
  input  logic              q_und,
  output mode_e             mode_o,
  output logic              flush_o,
  output logic [REC_W-1:0]  rec_o
);

  function automatic logic [CODE_W-1:0] clamp(input logic [CODE_W-1:0] c,
                                              input logic hi, input logic lo);
    if (hi)      return '1;
    else if (lo) return '0;
    else         return c;
  endfunction

  mode_e mode_q;
  logic  ph_q;
  logic  any_oor;

  assign flush_o = (mode_e'(demux_en) != mode_q);
  assign mode_o  = mode_q;
  assign any_oor = i_ovr | i_und | q_ovr | q_und;
  assign rec_o   = {~flush_o, ph_q, any_oor,
                    clamp(i_code, i_ovr, i_und), clamp(q_code, q_ovr, q_und)};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode_e'(demux_en);
      ph_q   <= 1'b0;
    end else if (flush_o) begin
      mode_q <= mode_e'(demux_en);
      ph_q   <= 1'b0;
    end else begin
      ph_q   <= ~ph_q;
    end
  end

  // R10: after a flush edge the mode in force matches the request seen there
  a_r10_mode_taken: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> (mode_q == $past(mode_e'(demux_en))));

endmodule

// File: rtl/dmx_delay.sv
// Fixed-length record delay line with two taps. Data bits carry no reset so
// the chain maps onto shift-register or RAM resources; only valid bits reset.
module dmx_delay #(
  parameter int unsigned REC_W = 19,
  parameter int unsigned DEPTH = 14,
  parameter int unsigned TAP_A = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_i,
  input  logic [REC_W-1:0] rec_i,
  output logic [REC_W-1:0] tap_a_o,
  output logic [REC_W-1:0] tap_b_o
);

  localparam int unsigned VLD = REC_W - 1;

  logic [REC_W-2:0] dat [DEPTH];
  logic [DEPTH-1:0] vld;

  for (genvar j = 0; j < DEPTH; j++) begin : g_stage
    if (j == 0) begin : g_head
      always_ff @(posedge clk) dat[0] <= rec_i[REC_W-2:0];
      always_ff @(posedge clk) begin
        if (rst) vld[0] <= 1'b0;
        else     vld[0] <= rec_i[VLD];
      end
    end else begin : g_body
      always_ff @(posedge clk) dat[j] <= dat[j-1];
      always_ff @(posedge clk) begin
        if (rst) vld[j] <= 1'b0;
        else     vld[j] <= vld[j-1] & ~flush_i;
      end
    end
  end

  assign tap_a_o = {vld[TAP_A], dat[TAP_A]};
  assign tap_b_o = {vld[DEPTH-1], dat[DEPTH-1]};

  // R10: a flush leaves nothing valid at the far end of the chain
  a_r10_chain_cleared: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !tap_b_o[VLD]);

endmodule

// File: rtl/dmx_steer.sv
// Output registers: routes tapped records to primary / delayed buses.
module dmx_steer
  import dmx_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  localparam int unsigned REC_W = 2 * CODE_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode_i,
  input  logic              flush_i,
  input  logic [REC_W-1:0]  tap_p_i,
  input  logic [REC_W-1:0]  tap_d_i,
  output logic [CODE_W-1:0] pri_i_o,
  output logic [CODE_W-1:0] pri_q_o,
  output logic [CODE_W-1:0] dly_i_o,
  output logic [CODE_W-1:0] dly_q_o,
  output logic              valid_o,
  output logic              oor_o
);

  localparam int unsigned VLD = REC_W - 1;
  localparam int unsigned PH  = REC_W - 2;
  localparam int unsigned OOR = REC_W - 3;

  logic ld_p, ld_d;

  always_comb begin
    ld_p = !flush_i && tap_p_i[VLD] && ((mode_i == MODE_FULL) || !tap_p_i[PH]);
    ld_d = !flush_i && (mode_i == MODE_SPLIT) && tap_d_i[VLD] && tap_d_i[PH];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pri_i_o <= '0;
      pri_q_o <= '0;
      dly_i_o <= '0;
      dly_q_o <= '0;
      valid_o <= 1'b0;
      oor_o   <= 1'b0;
    end else begin
      valid_o <= ld_p;
      if (ld_p) begin
        pri_i_o <= tap_p_i[2*CODE_W-1:CODE_W];
        pri_q_o <= tap_p_i[CODE_W-1:0];
        oor_o   <= tap_p_i[OOR] | (ld_d & tap_d_i[OOR]);
      end
      if (ld_d) begin
        dly_i_o <= tap_d_i[2*CODE_W-1:CODE_W];
        dly_q_o <= tap_d_i[CODE_W-1:0];
      end
    end
  end

  // R1: reset clears the output side
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!valid_o && !oor_o && pri_i_o == '0 && dly_q_o == '0));

  // R8: full-rate mode leaves the delayed buses untouched
  a_r8_dly_hold: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_FULL) |=> ($stable(dly_i_o) && $stable(dly_q_o)));

  // R9: split mode never strobes on consecutive edges
  a_r9_split_gap: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_SPLIT && valid_o) |=> !valid_o);

  // R9: primary buses move only together with the strobe
  a_r9_pri_on_valid: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(pri_i_o) && $stable(pri_q_o)));

  // R10: no strobe right after a flush edge
  a_r10_flush_quiet: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !valid_o);

endmodule

// File: rtl/dmx_out_pipe.sv
module dmx_out_pipe
  import dmx_pkg::*;
#(
  parameter int unsigned CODE_W  = DEF_CODE_W,
  parameter int unsigned LAT_PRI = DEF_LAT_PRI
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              demux_en,
  input  logic [CODE_W-1:0] i_code,
  input  logic [CODE_W-1:0] q_code,
  input  logic              i_ovr,
  input  logic              i_und,
  input  logic              q_ovr,
  input  logic              q_und,
  output logic [CODE_W-1:0] pri_i,
  output logic [CODE_W-1:0] pri_q,
  output logic [CODE_W-1:0] dly_i,
  output logic [CODE_W-1:0] dly_q,
  output logic              valid,
  output logic              oor
);

  localparam int unsigned REC_W   = 2 * CODE_W + 3;
  localparam int unsigned LAT_DLY = LAT_PRI + 1;

  mode_e            mode_q;
  logic             flush;
  logic [REC_W-1:0] rec, tap_p, tap_d;

  dmx_front #(.CODE_W(CODE_W)) u_front (
    .clk(clk), .rst(rst), .demux_en(demux_en),
    .i_code(i_code), .q_code(q_code),
    .i_ovr(i_ovr), .i_und(i_und), .q_ovr(q_ovr), .q_und(q_und),
    .mode_o(mode_q), .flush_o(flush), .rec_o(rec)
  );

  dmx_delay #(.REC_W(REC_W), .DEPTH(LAT_DLY), .TAP_A(LAT_PRI - 1)) u_delay (
    .clk(clk), .rst(rst), .flush_i(flush), .rec_i(rec),
    .tap_a_o(tap_p), .tap_b_o(tap_d)
  );

  dmx_steer #(.CODE_W(CODE_W)) u_steer (
    .clk(clk), .rst(rst), .mode_i(mode_q), .flush_i(flush),
    .tap_p_i(tap_p), .tap_d_i(tap_d),
    .pri_i_o(pri_i), .pri_q_o(pri_q), .dly_i_o(dly_i), .dly_q_o(dly_q),
    .valid_o(valid), .oor_o(oor)
  );

endmodule

// File: tb/dmx_out_pipe_tb.sv
module dmx_out_pipe_tb;

  localparam int LAT = 13;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1, demux_en = 1'b0;
  logic [7:0] i_code = '0, q_code = '0;
  logic       i_ovr = 0, i_und = 0, q_ovr = 0, q_und = 0;
  logic [7:0] pri_i, pri_q, dly_i, dly_q;
  logic       valid, oor;

  dmx_out_pipe u_dut (
    .clk(clk), .rst(rst), .demux_en(demux_en),
    .i_code(i_code), .q_code(q_code),
    .i_ovr(i_ovr), .i_und(i_und), .q_ovr(q_ovr), .q_und(q_und),
    .pri_i(pri_i), .pri_q(pri_q), .dly_i(dly_i), .dly_q(dly_q),
    .valid(valid), .oor(oor)
  );

  // {i_code, q_code, i_ovr, i_und, q_ovr, q_und}
  localparam logic [19:0] VEC [24] = '{
    {8'h10, 8'h20, 4'b0000}, {8'h11, 8'h21, 4'b0000},
    {8'h80, 8'h7F, 4'b1000}, {8'h33, 8'hC4, 4'b0000},
    {8'h45, 8'h56, 4'b0100}, {8'h67, 8'h78, 4'b0000},
    {8'h89, 8'h9A, 4'b0010}, {8'hAB, 8'hBC, 4'b0001},
    {8'hCD, 8'hDE, 4'b1100}, {8'hEF, 8'h01, 4'b0011},
    {8'h02, 8'h13, 4'b0000}, {8'h24, 8'h35, 4'b0000},
    {8'hFE, 8'h00, 4'b0000}, {8'h00, 8'hFF, 4'b0000},
    {8'h5A, 8'hA5, 4'b1001}, {8'h3C, 8'hC3, 4'b0110},
    {8'h71, 8'h17, 4'b0000}, {8'h62, 8'h26, 4'b1000},
    {8'h53, 8'h35, 4'b0000}, {8'h44, 8'h44, 4'b0000},
    {8'h9E, 8'hE9, 4'b0010}, {8'hB7, 8'h7B, 4'b0000},
    {8'hC8, 8'h8C, 4'b0000}, {8'hD9, 8'h9D, 4'b0100}
  };

  int n_chk = 0, n_bad = 0;
  int e = 0;
  always @(posedge clk) e++;

  logic [7:0] hi [1024];
  logic [7:0] hq [1024];
  logic       ho [1024];
  logic       rh [1024];
  int   s = 0, vidx = 0;
  logic cur_mode = 1'b0;
  logic [7:0] ep_i = 0, ep_q = 0, ed_i = 0, ed_q = 0;
  logic ev = 0, eo = 0;

  function automatic logic [7:0] clamp(input logic [7:0] c, input logic hiv, input logic lov);
    if (hiv) return 8'hFF;
    if (lov) return 8'h00;
    return c;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s edge %0d: actual %0h expected %0h", tag, e, act, exp);
    end
  endtask

  // expected outputs after edge e, from the requirements
  task automatic check_edge();
    int k;
    k = e - LAT;
    if (rh[e]) begin
      ep_i = 0; ep_q = 0; ed_i = 0; ed_q = 0; ev = 0; eo = 0;
    end else if (k >= s) begin
      if (!cur_mode) begin
        ev = 1; ep_i = hi[k]; ep_q = hq[k]; eo = ho[k];
      end else if (((k - s) % 2) == 0) begin
        ev = 1; ep_i = hi[k]; ep_q = hq[k]; eo = ho[k];
        if (k - 1 >= s) begin
          ed_i = hi[k-1]; ed_q = hq[k-1]; eo = ho[k] | ho[k-1];
        end
      end else ev = 0;
    end else ev = 0;

    if (rh[e]) begin
      chk("R1 pri_i", pri_i, ep_i); chk("R1 pri_q", pri_q, ep_q);
      chk("R1 dly_i", dly_i, ed_i); chk("R1 dly_q", dly_q, ed_q);
      chk("R1 valid", valid, ev);   chk("R1 oor", oor, eo);
    end else begin
      chk(cur_mode ? "R4/R2 pri_i" : "R3/R2 pri_i", pri_i, ep_i);
      chk(cur_mode ? "R4/R2 pri_q" : "R3/R2 pri_q", pri_q, ep_q);
      chk(cur_mode ? "R5 dly_i" : "R8 dly_i", dly_i, ed_i);
      chk(cur_mode ? "R5 dly_q" : "R8 dly_q", dly_q, ed_q);
      chk((e < s + LAT) ? "R10 valid" : (cur_mode ? "R9 valid" : "R3 valid"), valid, ev);
      chk(cur_mode ? "R7 oor" : "R6 oor", oor, eo);
    end
  endtask

  task automatic cyc(input logic m, input logic r);
    logic [19:0] v;
    @(negedge clk);
    check_edge();
    rst = r; rh[e+1] = r; demux_en = m;
    if (r) begin cur_mode = m; s = e + 2; end
    else if (m != cur_mode) begin cur_mode = m; s = e + 2; end  // R10 flush
    v = VEC[vidx % 24]; vidx++;
    {i_code, q_code, i_ovr, i_und, q_ovr, q_und} = v;
    hi[e+1] = clamp(v[19:12], v[3], v[2]);
    hq[e+1] = clamp(v[11:4], v[1], v[0]);
    ho[e+1] = |v[3:0];
  endtask

  initial begin
    for (int j = 0; j < 1024; j++) rh[j] = 1'b0;
    rh[1] = 1'b1; rh[0] = 1'b1;
    for (int j = 0; j < 3; j++) cyc(1'b0, 1'b1);
    for (int j = 0; j < 40; j++) cyc(1'b0, 1'b0);
    for (int j = 0; j < 40; j++) cyc(1'b1, 1'b0);
    for (int j = 0; j < 30; j++) cyc(1'b0, 1'b0);
    for (int j = 0; j < 3; j++) cyc(1'b1, 1'b1);
    for (int j = 0; j < 36; j++) cyc(1'b1, 1'b0);
    for (int j = 0; j < 24; j++) cyc(1'b0, 1'b0);
    @(negedge clk);
    check_edge();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule